// File: doc/BRIEF.md
# Load/Store-Multiple Micro-op Sequencer

This block takes one decoded block-transfer instruction and breaks it into a stream of simple micro-ops, one per cycle. The instruction carries a 16-bit register list, a direction bit, a pre/post indexing bit, a writeback bit, a load/store bit, a user-bank/status bit, an opcode-bit-15 flag and a 4-bit base register index. The sequencer emits the micro-ops in this order:

1. A copy of the base into a temporary register.
2. One load or store for each register in the list.
3. An optional base-adjust micro-op when writeback is requested.

The block works out the signed starting offset from the number of registers in the list and the addressing mode. It remaps registers to the user bank when that is requested. It also substitutes an exception-return load for a load of the program counter in the status form.

Both edges use valid/ready handshakes. A new instruction is accepted only while the sequencer is idle. While the output is stalled, the micro-op on offer is held unchanged. The block does not execute micro-ops and does not access memory.

Top module: `lsm_uop_seq`

## Requirements
- R1: The micro-op emitted first for an accepted instruction is an add-immediate (kind code 0) with `out_ra` = 16 (the temporary register), `out_rb` = the base index, `out_imm` = 0 and `out_up` = 1.
- R2: One transfer micro-op follows for each set bit of the list, in ascending bit order. Each has `out_rb` = 16, and its `out_ra` comes from the bit index (after R5).
- R3: The offset of the first transfer is 0 for up and 4×count−4 for down. It is 4 larger when pre-indexing is set.
- R4: Each later transfer's offset is the previous one plus 4 (up) or minus 4 (down). `out_up` of a transfer equals the direction bit.
- R5: When the user bit is set and op15 is clear, list indices 8 to 14 are sent as index+16, and all other indices are sent unchanged. Otherwise no index is remapped.
- R6: Transfer kinds are: load = 2, exception-return load = 3, store = 4. Kind 3 is used only for a load of index 15 when both the user bit and op15 are set.
- R7: With writeback set, a final micro-op follows the transfers. It is kind 0 (up) or 1 (down), with `out_ra` = `out_rb` = the base index and `out_imm` = 4×count.
- R8: Only the final micro-op of an instruction has `out_last` = 1. An empty list yields just the copy, plus the adjust when writeback is set.
- R9: `in_ready` is high only when no micro-op is on offer. While `out_ready` is low, the offered micro-op stays unchanged, and no micro-op is skipped or repeated.
- R10: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1, even if reset is applied mid-sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction will be taken |
| in_reglist | input | 16 | Register list |
| in_up | input | 1 | Direction: 1 up, 0 down |
| in_pre | input | 1 | Pre-indexed addressing |
| in_wback | input | 1 | Base writeback requested |
| in_load | input | 1 | 1 load, 0 store |
| in_usr | input | 1 | User-bank / status form |
| in_op15 | input | 1 | Opcode bit 15 |
| in_base | input | 4 | Base register index |
| out_valid | output | 1 | Micro-op on offer |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_kind | output | 3 | 0 add-imm, 1 sub-imm, 2 load, 3 exception-return load, 4 store |
| out_ra | output | 5 | Destination or data register index |
| out_rb | output | 5 | Source or address register index |
| out_imm | output | 8 | Offset or adjust amount |
| out_up | output | 1 | Offset direction |
| out_last | output | 1 | Final micro-op of the instruction |

## Verification
Some rules are checked by the assertions on every cycle:
- every accepted instruction opens with the zero-add copy into register 16;
- a stalled micro-op does not change;
- `in_ready` stays low while a micro-op is on offer;
- successive transfer offsets step by exactly 4 in the latched direction;
- the exception-return kind appears only on index 15;
- no remapped index is left inside 8 to 14 when the user bit is set;
- nothing follows a micro-op marked last.

The scenarios in the bench show the rest. These are the full content of each sequence against an independent model: ascending order, starting offsets for every addressing mode, the writeback amount, empty lists, full lists, stalls, and reset taken mid-sequence.

// File: rtl/lsm_pkg.sv
// Shared types for the load/store-multiple micro-op sequencer.
// Assumes the kind codes below are decoded unchanged by the consumer.
package lsm_pkg;

    typedef enum logic [2:0] {
        UOP_ADDI  = 3'd0,
        UOP_SUBI  = 3'd1,
        UOP_LOAD  = 3'd2,
        UOP_LDRET = 3'd3,
        UOP_STORE = 3'd4
    } uop_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_COPY,
        SQ_XFER,
        SQ_ADJ
    } sq_state_e;

    typedef struct packed {
        logic up;
        logic pre;
        logic wback;
        logic load;
        logic usr;
        logic op15;
    } lsm_mode_t;

endpackage

// File: rtl/lsm_lowbit.sv
// Finds the lowest set bit of a pending mask.
// Returns its index, the mask with that bit cleared, and a flag telling
// whether it was the only bit left.
// Assumes the mask is nonzero whenever idx is used.
module lsm_lowbit #(
    parameter int N   = 16,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   mask,
    output logic [IDW-1:0] idx,
    output logic [N-1:0]   rest,
    output logic           single
);
    // Priority scan from the top, so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDW'(i);
        end
    end

    // Clear the lowest set bit and flag the last pending bit.
    always_comb begin
        rest   = mask & (mask - N'(1));
        single = (mask != '0) && (rest == '0);
    end
endmodule

// File: rtl/lsm_start_off.sv
// Counts the set bits of a register list.
// Derives the first transfer offset and the writeback adjust amount.
// Assumes OFFW can hold STEP*N.
module lsm_start_off #(
    parameter int N    = 16,
    parameter int OFFW = 8,
    parameter int STEP = 4
) (
    input  logic [N-1:0]    list,
    input  logic            up,
    input  logic            pre,
    output logic [OFFW-1:0] start,
    output logic [OFFW-1:0] total
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt;

    // Population count of the list.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) cnt = cnt + CW'(list[i]);
    end

    // Start offset: 0 going up, count*STEP-STEP going down, plus STEP if pre.
    always_comb begin
        total = OFFW'(cnt) * OFFW'(STEP);
        start = up ? '0 : total - OFFW'(STEP);
        if (pre) start = start + OFFW'(STEP);
    end
endmodule

// File: rtl/lsm_reg_map.sv
// Maps a list index to the register index actually transferred.
// Also flags the exception-return load form.
// Assumes the banked window [BANK_LO, BANK_HI] is shifted up by BANK_ADD.
module lsm_reg_map #(
    parameter int LW       = 4,
    parameter int IW       = 5,
    parameter int PC_IDX   = 15,
    parameter int BANK_LO  = 8,
    parameter int BANK_HI  = 14,
    parameter int BANK_ADD = 16
) (
    input  logic [LW-1:0] reg_in,
    input  logic          usr,
    input  logic          op15,
    input  logic          load,
    output logic [IW-1:0] reg_out,
    output logic          ret
);
    logic in_bank;

    // User-bank remap applies only in the user form without op15.
    always_comb begin
        in_bank = (int'(reg_in) >= BANK_LO) && (int'(reg_in) <= BANK_HI);
        reg_out = IW'(reg_in);
        if (usr && !op15 && in_bank) reg_out = IW'(reg_in) + IW'(BANK_ADD);
    end

    // Exception-return form: a load of the PC in the status variant.
    always_comb ret = usr && op15 && load && (int'(reg_in) == PC_IDX);
endmodule

// File: rtl/lsm_uop_seq.sv
// Load/store-multiple micro-op sequencer (top).
// Latches one block-transfer instruction.
// Emits the base copy, one transfer per listed register and an optional
// base adjust, one micro-op per cycle under a valid/ready handshake.
// Assumes out_* are consumed only when out_valid && out_ready.
module lsm_uop_seq #(
    parameter int NREGS   = 16,
    parameter int IDX_W   = 5,
    parameter int OFF_W   = 8,
    parameter int STEP    = 4,
    parameter int TMP_IDX = 16,
    parameter int PC_IDX  = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [NREGS-1:0]         in_reglist,
    input  logic                     in_up,
    input  logic                     in_pre,
    input  logic                     in_wback,
    input  logic                     in_load,
    input  logic                     in_usr,
    input  logic                     in_op15,
    input  logic [$clog2(NREGS)-1:0] in_base,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [2:0]               out_kind,
    output logic [IDX_W-1:0]         out_ra,
    output logic [IDX_W-1:0]         out_rb,
    output logic [OFF_W-1:0]         out_imm,
    output logic                     out_up,
    output logic                     out_last
);
    import lsm_pkg::*;

    localparam int REG_W = $clog2(NREGS);

    sq_state_e        sq_q;
    lsm_mode_t        mode_q;
    logic [NREGS-1:0] pend_q;
    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] total_q;
    logic [REG_W-1:0] base_q;

    logic [REG_W-1:0] cur_idx;
    logic [NREGS-1:0] pend_rest;
    logic             one_left;
    logic [OFF_W-1:0] start_off;
    logic [OFF_W-1:0] total_off;
    logic [IDX_W-1:0] mapped_idx;
    logic             is_ret;
    logic             fire;

    lsm_lowbit #(.N(NREGS), .IDW(REG_W)) u_lowbit (
        .mask   (pend_q),
        .idx    (cur_idx),
        .rest   (pend_rest),
        .single (one_left)
    );

    lsm_start_off #(.N(NREGS), .OFFW(OFF_W), .STEP(STEP)) u_start (
        .list  (in_reglist),
        .up    (in_up),
        .pre   (in_pre),
        .start (start_off),
        .total (total_off)
    );

    lsm_reg_map #(.LW(REG_W), .IW(IDX_W), .PC_IDX(PC_IDX)) u_map (
        .reg_in  (cur_idx),
        .usr     (mode_q.usr),
        .op15    (mode_q.op15),
        .load    (mode_q.load),
        .reg_out (mapped_idx),
        .ret     (is_ret)
    );

    // Handshake flags derived from the sequencer state.
    always_comb begin
        in_ready  = (sq_q == SQ_IDLE);
        out_valid = (sq_q != SQ_IDLE);
        fire      = out_valid && out_ready;
    end

    // Micro-op fields for the current state.
    always_comb begin
        out_kind = UOP_ADDI;
        out_ra   = '0;
        out_rb   = '0;
        out_imm  = '0;
        out_up   = 1'b1;
        out_last = 1'b0;
        case (sq_q)
            SQ_COPY: begin
                out_ra   = IDX_W'(TMP_IDX);
                out_rb   = IDX_W'(base_q);
                out_last = (pend_q == '0) && !mode_q.wback;
            end
            SQ_XFER: begin
                out_kind = is_ret      ? UOP_LDRET :
                           mode_q.load ? UOP_LOAD  : UOP_STORE;
                out_ra   = mapped_idx;
                out_rb   = IDX_W'(TMP_IDX);
                out_imm  = off_q;
                out_up   = mode_q.up;
                out_last = one_left && !mode_q.wback;
            end
            SQ_ADJ: begin
                out_kind = mode_q.up ? UOP_ADDI : UOP_SUBI;
                out_ra   = IDX_W'(base_q);
                out_rb   = IDX_W'(base_q);
                out_imm  = total_q;
                out_up   = mode_q.up;
                out_last = 1'b1;
            end
            default: ;
        endcase
    end

    // Sequencer state: capture when idle, advance only on an output handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q    <= SQ_IDLE;
            mode_q  <= '0;
            pend_q  <= '0;
            off_q   <= '0;
            total_q <= '0;
            base_q  <= '0;
        end else begin
            case (sq_q)
                SQ_IDLE: if (in_valid) begin
                    mode_q  <= '{up: in_up, pre: in_pre, wback: in_wback,
                                 load: in_load, usr: in_usr, op15: in_op15};
                    pend_q  <= in_reglist;
                    off_q   <= start_off;
                    total_q <= total_off;
                    base_q  <= in_base;
                    sq_q    <= SQ_COPY;
                end
                SQ_COPY: if (fire) begin
                    if (pend_q != '0)      sq_q <= SQ_XFER;
                    else if (mode_q.wback) sq_q <= SQ_ADJ;
                    else                   sq_q <= SQ_IDLE;
                end
                SQ_XFER: if (fire) begin
                    pend_q <= pend_rest;
                    off_q  <= mode_q.up ? off_q + OFF_W'(STEP) : off_q - OFF_W'(STEP);
                    if (one_left) sq_q <= mode_q.wback ? SQ_ADJ : SQ_IDLE;
                end
                SQ_ADJ: if (fire) sq_q <= SQ_IDLE;
                default: sq_q <= SQ_IDLE;
            endcase
        end
    end

    // R1: an accepted instruction opens with the zero-add copy into the temporary register.
    p_copy_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_kind == UOP_ADDI &&
            out_ra == IDX_W'(TMP_IDX) && out_imm == '0));

    // R4: consecutive transfers step the offset by STEP in the latched direction.
    p_xfer_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sq_q == SQ_XFER && !one_left) |=>
            (out_imm == ($past(mode_q.up) ? $past(out_imm) + OFF_W'(STEP)
                                          : $past(out_imm) - OFF_W'(STEP))));

    // R5: no index inside the banked window leaves the block in the remapping form.
    p_bank_remap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q == SQ_XFER && mode_q.usr && !mode_q.op15) |->
            !(out_ra >= IDX_W'(8) && out_ra <= IDX_W'(14)));

    // R6: the exception-return kind is only ever used for the PC.
    p_ret_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == UOP_LDRET) |-> (out_ra == IDX_W'(PC_IDX)));

    // R8: after the last micro-op is taken, nothing more is offered.
    p_last_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_last) |=> !out_valid);

    // R9: a stalled micro-op stays the same.
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
            $stable(out_ra) && $stable(out_rb) && $stable(out_imm) && $stable(out_last)));

    // R9: no new instruction is accepted while a micro-op is on offer.
    p_busy_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
endmodule

// File: tb/lsm_uop_seq_tb.sv
// Self-checking bench for lsm_uop_seq.
// Walks a table of instructions against a model derived from the requirements,
// then runs directed stall and reset cases.
module lsm_uop_seq_tb_top;
    typedef struct packed {
        logic [15:0] list;
        logic        up;
        logic        pre;
        logic        wb;
        logic        load;
        logic        usr;
        logic        op15;
        logic [3:0]  base;
        logic [4:0]  exp_n;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'h00F1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3,  5'd7},
        '{16'h8101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd13, 5'd4},
        '{16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0,  5'd18},
        '{16'hC000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd2,  5'd4},
        '{16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7,  5'd2},
        '{16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9,  5'd1},
        '{16'h7F80, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1,  5'd10},
        '{16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5,  5'd2},
        '{16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd14, 5'd18}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_reglist = '0;
    logic        in_up = 1'b0, in_pre = 1'b0, in_wback = 1'b0;
    logic        in_load = 1'b0, in_usr = 1'b0, in_op15 = 1'b0;
    logic [3:0]  in_base = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  out_kind;
    logic [4:0]  out_ra, out_rb;
    logic [7:0]  out_imm;
    logic        out_up, out_last;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [2:0] e_kind [20];
    logic [4:0] e_ra   [20];
    logic [4:0] e_rb   [20];
    logic [7:0] e_imm  [20];
    logic       e_up   [20];
    logic       e_last [20];
    int         e_n;

    always #10 clk = ~clk;

    lsm_uop_seq dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_reglist(in_reglist), .in_up(in_up), .in_pre(in_pre), .in_wback(in_wback),
        .in_load(in_load), .in_usr(in_usr), .in_op15(in_op15), .in_base(in_base),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_ra(out_ra), .out_rb(out_rb), .out_imm(out_imm), .out_up(out_up),
        .out_last(out_last)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int k, input int ra, input int rb, input int imm, input logic up);
        e_kind[e_n] = 3'(k);
        e_ra[e_n]   = 5'(ra);
        e_rb[e_n]   = 5'(rb);
        e_imm[e_n]  = 8'(imm);
        e_up[e_n]   = up;
        e_last[e_n] = 1'b0;
        e_n++;
    endtask

    // Model of the expected sequence, built only from the requirements.
    task automatic build(input vec_t v);
        int cnt = 0;
        int off;
        e_n = 0;
        for (int r = 0; r < 16; r++) if (v.list[r]) cnt++;
        push(0, 16, v.base, 0, 1'b1);                             // R1
        off = v.up ? 0 : cnt * 4 - 4;                             // R3
        if (v.pre) off += 4;
        for (int r = 0; r < 16; r++) begin
            if (v.list[r]) begin
                int ra = r;
                int k;
                if (v.usr && !v.op15 && r >= 8 && r <= 14) ra = r + 16;   // R5
                k = v.load ? ((v.usr && v.op15 && r == 15) ? 3 : 2) : 4;  // R6
                push(k, ra, 16, off, v.up);                               // R2
                off = v.up ? off + 4 : off - 4;                           // R4
            end
        end
        if (v.wb) push(v.up ? 0 : 1, v.base, v.base, cnt * 4, v.up);      // R7
        e_last[e_n - 1] = 1'b1;                                           // R8
    endtask

    // Offer one instruction and check every micro-op; stall inserts ready gaps.
    task automatic run(input vec_t v, input bit stall);
        int idx = 0;
        int cyc = 0;
        build(v);
        chk("R8 sequence length", e_n, int'(v.exp_n));
        @(negedge clk);
        in_reglist = v.list; in_up = v.up; in_pre = v.pre; in_wback = v.wb;
        in_load = v.load; in_usr = v.usr; in_op15 = v.op15; in_base = v.base;
        in_valid = 1'b1;
        chk("R9 in_ready when idle", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        while (idx < e_n && cyc < 200) begin
            out_ready = stall ? (cyc % 3 != 1) : 1'b1;
            chk("R9 out_valid during sequence", int'(out_valid), 1);
            chk("R9 in_ready low while busy", int'(in_ready), 0);
            chk("R1/R6/R7 kind", int'(out_kind), int'(e_kind[idx]));
            chk("R2/R5 ra", int'(out_ra), int'(e_ra[idx]));
            chk("R2 rb", int'(out_rb), int'(e_rb[idx]));
            chk("R3/R4/R7 imm", int'(out_imm), int'(e_imm[idx]));
            chk("R4 up flag", int'(out_up), int'(e_up[idx]));
            chk("R8 last flag", int'(out_last), int'(e_last[idx]));
            if (out_ready) idx++;
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        chk("R8 idle after last", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset out_valid", int'(out_valid), 0);
        chk("R10 reset in_ready", int'(in_ready), 1);

        for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);

        // R9: stalls on full and empty lists must neither skip nor repeat.
        run(VECS[2], 1'b1);
        run(VECS[4], 1'b1);
        run(VECS[8], 1'b1);

        // R10: reset taken in the middle of a sequence returns to idle.
        @(negedge clk);
        in_reglist = 16'h0F0F; in_up = 1'b1; in_wback = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 busy before reset", int'(out_valid), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 mid-sequence reset out_valid", int'(out_valid), 0);
        chk("R10 mid-sequence reset in_ready", int'(in_ready), 1);
        out_ready = 1'b0;

        // After the reset a normal sequence must run cleanly.
        run(VECS[0], 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule